// File: doc/BRIEF.md
# Packed Lane Variable Shifter

This block shifts each lane of a packed data vector by a distance of its own. The distance for a lane is taken from the same lane of a second vector, the count vector. The sign of the count picks the direction. A count of zero or more shifts left. A negative count shifts right by its magnitude. Lanes can be 8, 16, 32 or 64 bits wide. They can be read as signed, which gives an arithmetic right shift, or unsigned, which gives a logical right shift. The vector is either the full 128 bits or only its low 64 bits.

A count does not wrap modulo the lane width. A count whose magnitude reaches or exceeds the width gives a fixed result: zero, or for a signed right shift, copies of the lane's sign bit. Only the low byte of each count lane is used. Every control input is taken with the data on the cycle the valid strobe is high, so each operation can use a different mode. The result appears one clock later.

Top module: `vshift_unit`

## Requirements
- R1: Each lane's count is the low 8 bits of its count lane, read as a two's-complement value from -128 to 127. Count bits above bit 7 of the lane have no effect.
- R2: A count from 0 up to the lane width minus one shifts the lane left by that count, and zeros fill from the right.
- R3: A negative count whose magnitude is below the lane width shifts the lane right by that magnitude. With `sgn_i`=1 the shift is arithmetic (sign fill). With `sgn_i`=0 it is logical (zero fill).
- R4: A count equal to or greater than the lane width gives zero in that lane, whether the lane is signed or unsigned.
- R5: With `sgn_i`=1, a negative count whose magnitude is equal to or greater than the lane width sets every bit of the lane to the lane's sign bit.
- R6: With `sgn_i`=0, a count whose magnitude is equal to or greater than the lane width gives zero, in either direction.
- R7: The count -128 (low byte 0x80) is handled as a right shift of magnitude 128, so it saturates as R5 and R6 describe.
- R8: `size_i` selects the lane width: 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64. Lane k takes bits [k*W+W-1 : k*W], and no lane affects another.
- R9: With `half_i`=1, only the low 64 bits of `data_i` and `cnt_i` are used, and `res_o[127:64]` is zero.
- R10: `res_o` and `valid_o` are updated on the clock edge that samples `valid_i`=1, so the latency is one cycle. While `valid_i`=0, `valid_o` is 0 and `res_o` keeps its value. The synchronous reset `rst`=1 clears `valid_o` and `res_o`.
- R11: `size_i`, `sgn_i` and `half_i` are sampled with the data. Operations on consecutive cycles may use different modes, and each result follows its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| data_i | input | 128 | Packed data lanes |
| cnt_i | input | 128 | Packed count lanes, one count per data lane |
| size_i | input | 2 | Lane width select (0:8, 1:16, 2:32, 3:64) |
| sgn_i | input | 1 | 1: lanes are signed, 0: unsigned |
| half_i | input | 1 | 1: 64-bit vector, 0: 128-bit vector |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| res_o | output | 128 | Packed shifted lanes |

## Verification
Every result is due exactly one clock edge after the edge that samples `valid_i`. Each scenario task drives its operands on a falling edge and reads `valid_o` and `res_o` on the following falling edge, half a period after the registering edge. The back-to-back scenario presents a new operation on each falling edge. It reads the result of the previous operation on that edge before it drives the next one, so each result is paired with its own mode. The hold scenario drops `valid_i` and reads the outputs on the next two falling edges.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

  // Lane width encoding; the numeric value is the select on size_i.
  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_sz_e;

  localparam int NUM_SIZES = 4;
  localparam int CNT_BITS  = 8;
  localparam int MIN_LANE  = 8;

  function automatic int lane_bits(input int idx);
    return MIN_LANE << idx;
  endfunction

endpackage

// File: rtl/vshift_lane.sv
module vshift_lane #(
  parameter int LW = 8,
  parameter int CW = 8
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] cnt_i,
  input  logic          sgn_i,
  output logic [LW-1:0] y_o
);
  localparam int SW = $clog2(LW);

  logic [CW-1:0] c;
  logic          neg;
  logic [CW:0]   mag;
  logic          oor;
  logic [SW-1:0] amt;
  logic          fill;

  assign c    = cnt_i[CW-1:0];
  assign neg  = c[CW-1];
  // One extra bit so that the most negative count gets its true magnitude.
  assign mag  = neg ? ((CW+1)'(0) - {1'b1, c}) : {1'b0, c};
  assign oor  = (mag >= (CW+1)'(LW));
  assign amt  = mag[SW-1:0];
  assign fill = sgn_i & a_i[LW-1];

  always_comb begin
    if (!neg) begin
      y_o = oor ? '0 : (a_i << amt);
    end else if (oor) begin
      y_o = {LW{fill}};
    end else if (sgn_i) begin
      y_o = LW'($signed(a_i) >>> amt);
    end else begin
      y_o = a_i >> amt;
    end
  end

  always_comb begin
    if (!sgn_i && (mag >= (CW+1)'(LW)))
      assert_unsigned_sat_zero_R6: assert (y_o == '0);
    if (sgn_i && neg && (mag >= (CW+1)'(LW)))
      assert_signed_sat_fill_R5: assert (y_o == {LW{a_i[LW-1]}});
    if (!neg && (mag >= (CW+1)'(LW)))
      assert_left_sat_zero_R4: assert (y_o == '0);
  end

endmodule

// File: rtl/vshift_group.sv
module vshift_group #(
  parameter int VW = 128,
  parameter int LW = 8
) (
  input  logic [VW-1:0] a_i,
  input  logic [VW-1:0] cnt_i,
  input  logic          sgn_i,
  output logic [VW-1:0] y_o
);
  import vshift_pkg::*;

  localparam int NL = VW / LW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    vshift_lane #(
      .LW (LW),
      .CW (CNT_BITS)
    ) u_lane (
      .a_i   (a_i[l*LW +: LW]),
      .cnt_i (cnt_i[l*LW +: LW]),
      .sgn_i (sgn_i),
      .y_o   (y_o[l*LW +: LW])
    );
  end

endmodule

// File: rtl/vshift_unit.sv
module vshift_unit #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [VEC_W-1:0] data_i,
  input  logic [VEC_W-1:0] cnt_i,
  input  logic [1:0]       size_i,
  input  logic             sgn_i,
  input  logic             half_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o
);
  import vshift_pkg::*;

  localparam int HALF = VEC_W / 2;

  logic [VEC_W-1:0] grp_y [NUM_SIZES];
  logic [VEC_W-1:0] sel_y;
  logic [VEC_W-1:0] res_n;
  lane_sz_e         sz;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    vshift_group #(
      .VW (VEC_W),
      .LW (lane_bits(g))
    ) u_grp (
      .a_i   (data_i),
      .cnt_i (cnt_i),
      .sgn_i (sgn_i),
      .y_o   (grp_y[g])
    );
  end

  assign sz = lane_sz_e'(size_i);

  always_comb begin
    case (sz)
      LANE_8:  sel_y = grp_y[0];
      LANE_16: sel_y = grp_y[1];
      LANE_32: sel_y = grp_y[2];
      default: sel_y = grp_y[3];
    endcase
    res_n = half_i ? {{HALF{1'b0}}, sel_y[HALF-1:0]} : sel_y;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_n;
    end
  end

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(res_o));
  assert_half_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_i && half_i) |=> (res_o[VEC_W-1:HALF] == '0));

endmodule

// File: tb/vshift_unit_bench.sv
module vshift_unit_bench;
  localparam int  CLK_P = 10;
  localparam int  VW    = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid_i = 1'b0;
  logic [VW-1:0] data_i = '0;
  logic [VW-1:0] cnt_i = '0;
  logic [1:0]    size_i = 2'd0;
  logic          sgn_i = 1'b0;
  logic          half_i = 1'b0;
  logic          valid_o;
  logic [VW-1:0] res_o;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vshift_unit #(.VEC_W(VW)) u_vshift_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .data_i(data_i), .cnt_i(cnt_i),
    .size_i(size_i), .sgn_i(sgn_i), .half_i(half_i),
    .valid_o(valid_o), .res_o(res_o)
  );

  // Expected value written from the requirements.
  function automatic logic [VW-1:0] model(input logic [VW-1:0] d, input logic [VW-1:0] c,
                                          input logic [1:0] sz, input logic s, input logic h);
    logic [VW-1:0] r;
    int w;
    int nl;
    r  = '0;
    w  = 8 << sz;
    nl = (h ? 64 : VW) / w;
    for (int l = 0; l < nl; l++) begin
      logic [63:0] a;
      logic [63:0] mask;
      logic [63:0] y;
      logic signed [63:0] ax;
      int cv;
      int m;
      mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      a    = 64'(d >> (l*w)) & mask;
      cv   = int'($signed(c[l*w +: 8]));
      ax   = (a[w-1]) ? $signed(a | ~mask) : $signed(a);
      if (cv >= 0) begin
        y = (cv >= w) ? 64'd0 : (a << cv);
      end else begin
        m = -cv;
        if (m >= w) y = (s && a[w-1]) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'd0;
        else if (s) y = 64'(ax >>> m);
        else        y = a >> m;
      end
      r = r | (VW'(y & mask) << (l*w));
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [VW-1:0] exp_r, input logic exp_v);
    n_checks++;
    if (res_o !== exp_r || valid_o !== exp_v) begin
      n_errs++;
      $display("FAIL %s: res=%h valid=%b expected res=%h valid=%b", req, res_o, valid_o, exp_r, exp_v);
    end
  endtask

  // Drive one operation, read it back one edge later.
  task automatic run_op(input string req, input logic [VW-1:0] d, input logic [VW-1:0] c,
                        input logic [1:0] sz, input logic s, input logic h);
    @(negedge clk);
    valid_i = 1'b1; data_i = d; cnt_i = c; size_i = sz; sgn_i = s; half_i = h;
    @(negedge clk);
    check(req, model(d, c, sz, s, h), 1'b1);
    valid_i = 1'b0;
  endtask

  function automatic logic [VW-1:0] rep8(input logic [7:0] b);
    return {16{b}};
  endfunction

  task automatic t_reset;
    check("R10 reset", '0, 1'b0);
  endtask

  task automatic t_left_R2;
    run_op("R2 left 8b signed", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
           128'h0001_0203_0405_0607_0706_0504_0302_0100, 2'd0, 1'b1, 1'b0);
    run_op("R2 left 32b unsigned", 128'h8000_0001_1234_5678_FFFF_FFFF_0000_0003,
           128'h0000_001F_0000_0004_0000_0010_0000_0000, 2'd2, 1'b0, 1'b0);
    check("R2 literal 32b lane0", {96'h0, 32'h0000_0003} | (res_o & {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h0}), 1'b1);
  endtask

  task automatic t_right_R3;
    run_op("R3 right 8b signed", rep8(8'h80), rep8(8'hFD), 2'd0, 1'b1, 1'b0);
    check("R3 literal 0x80>>>3", rep8(8'hF0), 1'b1);
    run_op("R3 right 8b unsigned", rep8(8'h80), rep8(8'hFD), 2'd0, 1'b0, 1'b0);
    check("R3 literal 0x80>>3", rep8(8'h10), 1'b1);
    run_op("R3 right 16b mixed", 128'h8001_7FFF_F0F0_0F0F_8000_1234_FFFF_4000,
           128'h00FF_00FE_00F1_00F8_00FC_00FF_00F9_00F2, 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_highbits_R1;
    run_op("R1 16b high count bits", 128'h0001_0001_0001_0001_8000_8000_8000_8000,
           128'h7F02_FF03_0102_AA00_80FF_0001_FFFE_1201, 2'd1, 1'b1, 1'b0);
    run_op("R1 64b high count bits", 128'h0000_0000_0000_00FF_8000_0000_0000_0000,
           128'hFFFF_FFFF_FFFF_FF04_1234_5678_9ABC_DEFC, 2'd3, 1'b1, 1'b0);
  endtask

  task automatic t_sat_R4_R5_R6;
    run_op("R4 left >= width 8b", rep8(8'hFF), rep8(8'h08), 2'd0, 1'b1, 1'b0);
    check("R4 literal zero", '0, 1'b1);
    run_op("R4 left >= width 64b", {64'h1, 64'hFFFF_FFFF_FFFF_FFFF},
           {64'h0000_0000_0000_0040, 64'h0000_0000_0000_007F}, 2'd3, 1'b0, 1'b0);
    run_op("R5 signed right sat 32b", 128'h8000_0000_7FFF_FFFF_FFFF_0000_0000_FFFF,
           128'h0000_00E0_0000_00E0_0000_00C0_0000_00A0, 2'd2, 1'b1, 1'b0);
    check("R5 literal fill", 128'hFFFF_FFFF_0000_0000_FFFF_FFFF_0000_0000, 1'b1);
    run_op("R6 unsigned right sat 16b", {8{16'hFFFF}},
           128'h00F0_00E0_0010_0020_00F0_0080_00F1_0011, 2'd1, 1'b0, 1'b0);
  endtask

  task automatic t_min_R7;
    run_op("R7 -128 signed 64b", {64'h8000_0000_0000_0001, 64'h7000_0000_0000_0000},
           {64'h80, 64'h80}, 2'd3, 1'b1, 1'b0);
    check("R7 literal signed", {64'hFFFF_FFFF_FFFF_FFFF, 64'h0}, 1'b1);
    run_op("R7 -128 unsigned 8b", rep8(8'hC3), rep8(8'h80), 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_sizes_R8;
    for (int sz = 0; sz < 4; sz++)
      run_op("R8 lane size sweep", 128'h8765_4321_0FED_CBA9_F00D_CAFE_1357_9BDF,
             128'hFF01_FE02_FD03_FC04_0105_F906_7F07_8008, 2'(sz), 1'b1, 1'b0);
  endtask

  task automatic t_half_R9;
    run_op("R9 half 8b", 128'hFFFF_FFFF_FFFF_FFFF_0102_0408_1020_4080,
           128'h0101_0101_0101_0101_01FF_02FE_03FD_0480, 2'd0, 1'b0, 1'b1);
    run_op("R9 half 64b", {64'hDEAD_BEEF_DEAD_BEEF, 64'h8000_0000_0000_0000},
           {64'h1, 64'hFC}, 2'd3, 1'b1, 1'b1);
    check("R9 literal", {64'h0, 64'hF800_0000_0000_0000}, 1'b1);
  endtask

  task automatic t_hold_R10;
    logic [VW-1:0] last;
    last = res_o;
    @(negedge clk);
    data_i = ~data_i; cnt_i = '0;
    check("R10 idle valid low", last, 1'b0);
    @(negedge clk);
    check("R10 idle hold", last, 1'b0);
  endtask

  task automatic t_b2b_R11;
    logic [VW-1:0] d [3];
    logic [VW-1:0] c [3];
    logic [1:0]    z [3];
    logic          s [3];
    logic          h [3];
    d[0] = rep8(8'h90);  c[0] = rep8(8'hFE); z[0] = 2'd0; s[0] = 1'b1; h[0] = 1'b0;
    d[1] = rep8(8'h90);  c[1] = rep8(8'hFE); z[1] = 2'd1; s[1] = 1'b0; h[1] = 1'b0;
    d[2] = rep8(8'h90);  c[2] = rep8(8'h03); z[2] = 2'd2; s[2] = 1'b1; h[2] = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      if (k > 0) check("R11 back-to-back", model(d[k-1], c[k-1], z[k-1], s[k-1], h[k-1]), 1'b1);
      valid_i = 1'b1; data_i = d[k]; cnt_i = c[k]; size_i = z[k]; sgn_i = s[k]; half_i = h[k];
      @(negedge clk);
    end
    check("R11 back-to-back last", model(d[2], c[2], z[2], s[2], h[2]), 1'b1);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_left_R2();
    t_right_R3();
    t_highbits_R1();
    t_sat_R4_R5_R6();
    t_min_R7();
    t_sizes_R8();
    t_half_R9();
    t_hold_R10();
    t_b2b_R11();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

endmodule